// File: doc/BRIEF.md
# Framed Data-Link Bit Inserter

This block supplies the data-link bit for each frame of an outgoing T1 multiframe. A framer pulses a strobe once per frame, together with the 0-based number of that frame inside the multiframe. The block decides whether that frame carries a data-link bit in the selected framing format. If it does, the block presents the bit on a serial output one clock later, marked by a valid pulse.

Two framing formats are supported. In the 24-frame format, the odd-numbered frames carry the data link. In the 72-frame format, frames 26 through 72 carry it. The bits come from one of two sources. The first is three 8-bit registers, snapshotted once per multiframe. The second is a show-ahead transmit byte FIFO that holds finished HDLC bytes or transparent bytes, sent LSB first. When the FIFO is empty, the block sends timefill: flag or idle in HDLC mode, and all ones in transparent mode. An optional control bit delays the start of a FIFO transmission until the first data-link slot of the next multiframe.

The FIFO path is driven by a three-state machine. In ST_FILL it sends timefill. It moves from ST_FILL to ST_SEND at a byte boundary when data is waiting and aligned start is off. It moves from ST_FILL to ST_ARM when data is waiting and aligned start is on. In ST_ARM it keeps sending timefill, moves to ST_SEND at the first data-link slot of a multiframe, and falls back to ST_FILL if the FIFO empties or aligned start is cleared. In ST_SEND it shifts out bytes. At each byte boundary it either pops the next byte or, if the FIFO is empty, returns to ST_FILL. Register mode holds the machine in ST_FILL with its bit counter cleared.

Top module: `dl_bit_inserter`

## Requirements
- R1: After reset, dl_valid_o and fifo_rd_o are 0, and dl_bit_o is 1.
- R2: With fmt_f72_i=0, a frame strobe on frame_num_i equal to 0, 2, …, 22 (frames 1, 3, …, 23) is a data-link slot. No other frame number is a slot. dl_valid_o pulses high for one cycle on the clock edge that follows a slot strobe, and is 0 otherwise.
- R3: With fmt_f72_i=1, frame numbers 25 through 71 (frames 26 to 72) are data-link slots, and frames 0 through 24 are not.
- R4: In register mode (mode_i=0), slot k of the multiframe sends dl_regs_i[k]. In the 24-frame format k is frame_num_i/2, and in the 72-frame format k is frame_num_i-25. Register mode never reads the FIFO.
- R5: In register mode in the 72-frame format, slots with k of 24 or more send 1.
- R6: The register word is captured at the frame-0 strobe. A change to dl_regs_i later in the multiframe has no effect on that multiframe and takes effect at the next one.
- R7: In FIFO modes (mode_i=1 HDLC, mode_i=2 transparent), each FIFO byte is sent LSB first over 8 consecutive slots. fifo_rd_o pulses in the slot cycle that sends bit 0, and then one byte is popped every 8 slots while data remains.
- R8: In HDLC mode with fill_idle_i=0 and the FIFO empty, the timefill is the byte 0x7E, sent LSB first and byte-aligned after data.
- R9: In HDLC mode with fill_idle_i=1, the timefill is all ones.
- R10: In transparent mode, the timefill is all ones regardless of fill_idle_i.
- R11: With mf_align_i=1, data that arrives while timefill is being sent is not read until the first data-link slot of the next multiframe (frame_num_i 0 in the 24-frame format). Its first bit goes out in that slot, even if a timefill byte is cut short.
- R12: fifo_rd_o is never high while fifo_empty_i is high, and is high only in a cycle with a frame strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| fmt_f72_i | input | 1 | 0: 24-frame format, 1: 72-frame format |
| mode_i | input | 2 | 0 register, 1 HDLC FIFO, 2 transparent FIFO |
| fill_idle_i | input | 1 | HDLC timefill: 0 flag 0x7E, 1 all ones |
| mf_align_i | input | 1 | Hold the start of a FIFO transmission until the multiframe start |
| frame_strobe_i | input | 1 | One-cycle pulse per frame from the framer |
| frame_num_i | input | 7 | 0-based frame number within the multiframe |
| dl_regs_i | input | 24 | Three 8-bit data-link registers; bit k feeds slot k |
| fifo_empty_i | input | 1 | Transmit FIFO empty |
| fifo_data_i | input | 8 | Show-ahead FIFO head byte |
| fifo_rd_o | output | 1 | FIFO pop strobe |
| dl_bit_o | output | 1 | Data-link bit |
| dl_valid_o | output | 1 | dl_bit_o holds a new slot bit |

## Verification
The bench builds the block with its default parameters: 8-bit bytes, three registers, and multiframes of 24 and 72 frames. With these values a run can strobe every frame number of both formats and cover every register bit. The same values make the bit counter's wrap from 7 to 0, the truncated flag byte at an aligned start, and the register positions past 24 in the long format all reachable within a few multiframes. Expected bits are worked out from slot counts and byte constants.

// File: rtl/dlink_pkg.sv
package dlink_pkg;
    typedef enum logic [1:0] {
        MODE_REG   = 2'd0,
        MODE_HDLC  = 2'd1,
        MODE_TRANS = 2'd2
    } dl_mode_e;

    typedef enum logic [1:0] {
        ST_FILL = 2'd0,
        ST_ARM  = 2'd1,
        ST_SEND = 2'd2
    } dl_state_e;

    localparam logic [7:0] FLAG_BYTE = 8'h7E;
    localparam logic [7:0] IDLE_BYTE = 8'hFF;
endpackage

// File: rtl/dl_slot_map.sv
module dl_slot_map #(
    parameter int ESF_FRAMES = 24,
    parameter int F72_FRAMES = 72,
    parameter int F72_FIRST  = 25,
    parameter int FRAME_W    = $clog2(F72_FRAMES)
) (
    input  logic               fmt_f72_i,
    input  logic [FRAME_W-1:0] frame_num_i,
    output logic               is_slot_o,
    output logic               first_o,
    output logic [FRAME_W-1:0] slot_idx_o
);
    always_comb begin
        if (fmt_f72_i) begin
            is_slot_o  = (frame_num_i >= FRAME_W'(F72_FIRST)) &&
                         (frame_num_i <  FRAME_W'(F72_FRAMES));
            slot_idx_o = frame_num_i - FRAME_W'(F72_FIRST);
        end else begin
            is_slot_o  = (frame_num_i < FRAME_W'(ESF_FRAMES)) && !frame_num_i[0];
            slot_idx_o = {1'b0, frame_num_i[FRAME_W-1:1]};
        end
        first_o = is_slot_o && (slot_idx_o == '0);
    end
endmodule

// File: rtl/dl_reg_src.sv
module dl_reg_src #(
    parameter int BYTE_W  = 8,
    parameter int NREG    = 3,
    parameter int FRAME_W = 7
) (
    input  logic                   clk_i,
    input  logic                   rst_ni,
    input  logic                   load_i,
    input  logic [NREG*BYTE_W-1:0] regs_i,
    input  logic [FRAME_W-1:0]     idx_i,
    output logic                   bit_o
);
    localparam int TOTAL = NREG * BYTE_W;
    localparam int SEL_W = $clog2(TOTAL);

    logic [TOTAL-1:0] shadow_q;
    logic [TOTAL-1:0] word;

    always_ff @(posedge clk_i) begin
        if (!rst_ni)     shadow_q <= '1;
        else if (load_i) shadow_q <= regs_i;
    end

    always_comb begin
        word  = load_i ? regs_i : shadow_q;
        bit_o = (idx_i < FRAME_W'(TOTAL)) ? word[idx_i[SEL_W-1:0]] : 1'b1;
    end
endmodule

// File: rtl/dl_fifo_fsm.sv
module dl_fifo_fsm
    import dlink_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              en_i,
    input  logic              slot_i,
    input  logic              first_i,
    input  logic              align_i,
    input  logic              fifo_empty_i,
    input  logic [BYTE_W-1:0] fifo_data_i,
    input  logic [BYTE_W-1:0] fill_byte_i,
    output logic              bit_o,
    output logic              rd_o
);
    localparam int CNT_W = $clog2(BYTE_W);

    dl_state_e         state_q, state_d;
    logic [CNT_W-1:0]  cnt_q;
    logic [BYTE_W-1:0] sh_q;
    logic              take, use_fill, cnt_zero;

    assign cnt_zero = (cnt_q == '0);

    // state register
    always_ff @(posedge clk_i) begin
        if (!rst_ni) state_q <= ST_FILL;
        else         state_q <= state_d;
    end

    // next state and outputs
    always_comb begin
        state_d  = state_q;
        take     = 1'b0;
        use_fill = 1'b0;
        if (!en_i) begin
            state_d = ST_FILL;
        end else begin
            unique case (state_q)
                ST_FILL: begin
                    if (slot_i) begin
                        if (cnt_zero && !fifo_empty_i && !align_i) begin
                            take    = 1'b1;
                            state_d = ST_SEND;
                        end else begin
                            use_fill = 1'b1;
                        end
                    end else if (!fifo_empty_i && align_i) begin
                        state_d = ST_ARM;
                    end
                end
                ST_ARM: begin
                    if (slot_i) begin
                        if (first_i && !fifo_empty_i) begin
                            take    = 1'b1;
                            state_d = ST_SEND;
                        end else begin
                            use_fill = 1'b1;
                        end
                    end else if (fifo_empty_i || !align_i) begin
                        state_d = ST_FILL;
                    end
                end
                ST_SEND: begin
                    if (slot_i && cnt_zero) begin
                        if (!fifo_empty_i) begin
                            take = 1'b1;
                        end else begin
                            use_fill = 1'b1;
                            state_d  = ST_FILL;
                        end
                    end
                end
                default: state_d = ST_FILL;
            endcase
        end
        rd_o  = take;
        bit_o = take ? fifo_data_i[0] : (use_fill ? fill_byte_i[cnt_q] : sh_q[cnt_q]);
    end

    // byte shifter and bit counter
    always_ff @(posedge clk_i) begin
        if (!rst_ni || !en_i) begin
            cnt_q <= '0;
            sh_q  <= '0;
        end else if (take) begin
            sh_q  <= fifo_data_i;
            cnt_q <= CNT_W'(1);
        end else if (slot_i) begin
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end

    // R12
    rd_not_empty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rd_o |-> !fifo_empty_i);

    // R11
    arm_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == ST_ARM && !first_i) |-> !rd_o);

    // R7
    mid_byte_no_rd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == ST_SEND && !cnt_zero) |-> !rd_o);
endmodule

// File: rtl/dl_bit_inserter.sv
module dl_bit_inserter
    import dlink_pkg::*;
#(
    parameter int BYTE_W     = 8,
    parameter int NREG       = 3,
    parameter int ESF_FRAMES = 24,
    parameter int F72_FRAMES = 72,
    parameter int F72_FIRST  = 25,
    parameter int FRAME_W    = $clog2(F72_FRAMES)
) (
    input  logic                   clk_i,
    input  logic                   rst_ni,
    input  logic                   fmt_f72_i,
    input  logic [1:0]             mode_i,
    input  logic                   fill_idle_i,
    input  logic                   mf_align_i,
    input  logic                   frame_strobe_i,
    input  logic [FRAME_W-1:0]     frame_num_i,
    input  logic [NREG*BYTE_W-1:0] dl_regs_i,
    input  logic                   fifo_empty_i,
    input  logic [BYTE_W-1:0]      fifo_data_i,
    output logic                   fifo_rd_o,
    output logic                   dl_bit_o,
    output logic                   dl_valid_o
);
    logic               is_slot, first, hit, reg_bit, fifo_bit, fifo_en, load;
    logic [FRAME_W-1:0] slot_idx;
    logic [BYTE_W-1:0]  fill_byte;
    dl_mode_e           mode;

    assign mode      = dl_mode_e'(mode_i);
    assign hit       = frame_strobe_i && is_slot;
    assign fifo_en   = (mode != MODE_REG);
    assign load      = frame_strobe_i && (frame_num_i == '0);
    assign fill_byte = (mode == MODE_HDLC && !fill_idle_i) ? BYTE_W'(FLAG_BYTE) : '1;

    dl_slot_map #(
        .ESF_FRAMES(ESF_FRAMES), .F72_FRAMES(F72_FRAMES),
        .F72_FIRST(F72_FIRST),   .FRAME_W(FRAME_W)
    ) u_map (
        .fmt_f72_i(fmt_f72_i), .frame_num_i(frame_num_i),
        .is_slot_o(is_slot),   .first_o(first), .slot_idx_o(slot_idx)
    );

    dl_reg_src #(.BYTE_W(BYTE_W), .NREG(NREG), .FRAME_W(FRAME_W)) u_regs (
        .clk_i(clk_i), .rst_ni(rst_ni), .load_i(load),
        .regs_i(dl_regs_i), .idx_i(slot_idx), .bit_o(reg_bit)
    );

    dl_fifo_fsm #(.BYTE_W(BYTE_W)) u_fsm (
        .clk_i(clk_i), .rst_ni(rst_ni), .en_i(fifo_en), .slot_i(hit),
        .first_i(first), .align_i(mf_align_i), .fifo_empty_i(fifo_empty_i),
        .fifo_data_i(fifo_data_i), .fill_byte_i(fill_byte),
        .bit_o(fifo_bit), .rd_o(fifo_rd_o)
    );

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            dl_valid_o <= 1'b0;
            dl_bit_o   <= 1'b1;
        end else begin
            dl_valid_o <= hit;
            if (hit) dl_bit_o <= fifo_en ? fifo_bit : reg_bit;
        end
    end

    // R2
    valid_after_strobe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        dl_valid_o |-> $past(frame_strobe_i));

    // R4
    reg_mode_no_rd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mode_i == 2'd0) |-> !fifo_rd_o);

    // R12
    rd_on_strobe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        fifo_rd_o |-> frame_strobe_i);
endmodule

// File: tb/dl_bit_inserter_tb.sv
module dl_bit_inserter_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fmt_f72 = 1'b0;
    logic [1:0]  mode = 2'd0;
    logic        fill_idle = 1'b0;
    logic        mf_align = 1'b0;
    logic        strobe = 1'b0;
    logic [6:0]  fnum = '0;
    logic [23:0] regs = '0;
    logic        fifo_empty;
    logic [7:0]  fifo_data;
    logic        fifo_rd, dl_bit, dl_valid;

    logic [7:0]  fmem [0:7];
    int          fcnt = 0;
    int          fptr;
    int          n_chk = 0, n_bad = 0;
    bit          done = 0;

    always #5 clk = ~clk;

    assign fifo_empty = (fptr >= fcnt);
    assign fifo_data  = fmem[fptr[2:0]];

    always_ff @(posedge clk) begin
        if (!rst_n)       fptr <= 0;
        else if (fifo_rd) fptr <= fptr + 1;
    end

    dl_bit_inserter u_dut (
        .clk_i(clk), .rst_ni(rst_n), .fmt_f72_i(fmt_f72), .mode_i(mode),
        .fill_idle_i(fill_idle), .mf_align_i(mf_align), .frame_strobe_i(strobe),
        .frame_num_i(fnum), .dl_regs_i(regs), .fifo_empty_i(fifo_empty),
        .fifo_data_i(fifo_data), .fifo_rd_o(fifo_rd), .dl_bit_o(dl_bit),
        .dl_valid_o(dl_valid)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic frame(input int f);
        @(negedge clk);
        strobe = 1'b1;
        fnum   = 7'(f);
        @(negedge clk);
        strobe = 1'b0;
    endtask

    function automatic logic fifo_stream(input int s, input int nbytes, input logic [7:0] fill);
        if (s < nbytes * 8) return fmem[s / 8][s % 8];
        return fill[(s - nbytes * 8) % 8];
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [23:0] w0, w1;
        int s;
        do_reset();
        // R1 reset state
        check("R1 valid", dl_valid, 0);
        check("R1 bit", dl_bit, 1);
        check("R1 rd", fifo_rd, 0);

        // R2 R4 R6: register mode, 24-frame format, two multiframes
        w0 = 24'hF03CA5; w1 = 24'h5A0FC3;
        regs = w0; mode = 2'd0; fmt_f72 = 1'b0;
        for (int m = 0; m < 2; m++) begin
            for (int f = 0; f < 24; f++) begin
                frame(f);
                check("R2 slot", dl_valid, (f % 2 == 0) ? 1 : 0);
                if (f % 2 == 0)
                    check("R4_R6 reg bit", dl_bit, (m == 0) ? w0[f/2] : w1[f/2]);
                if (m == 0 && f == 10) regs = w1;
            end
        end
        check("R4 no fifo read", fptr, 0);

        // R3 R5: register mode, 72-frame format
        fmt_f72 = 1'b1; regs = w0;
        for (int f = 0; f < 72; f++) begin
            frame(f);
            check("R3 slot", dl_valid, (f >= 25) ? 1 : 0);
            if (f >= 25)
                check("R5 reg bit", dl_bit, (f - 25 < 24) ? w0[f-25] : 1);
        end

        // R7 R8: HDLC, flag fill, 24-frame format
        fmem[0] = 8'h12; fmem[1] = 8'h9B; fmem[2] = 8'hC4;
        fcnt = 3; mode = 2'd1; fill_idle = 1'b0; fmt_f72 = 1'b0;
        do_reset();
        s = 0;
        for (int m = 0; m < 4; m++)
            for (int f = 0; f < 24; f += 2) begin
                frame(f);
                check("R7_R8 valid", dl_valid, 1);
                check("R7_R8 hdlc bit", dl_bit, fifo_stream(s, 3, 8'h7E));
                s++;
            end
        check("R7 bytes read", fptr, 3);

        // R9: HDLC idle fill, 72-frame format
        fmem[0] = 8'h00; fcnt = 1; fill_idle = 1'b1; fmt_f72 = 1'b1;
        do_reset();
        for (int f = 25; f < 72; f++) begin
            frame(f);
            check("R9 idle bit", dl_bit, fifo_stream(f - 25, 1, 8'hFF));
        end

        // R10: transparent fill is ones even with flag selected
        fmem[0] = 8'h5A; fcnt = 1; mode = 2'd2; fill_idle = 1'b0; fmt_f72 = 1'b0;
        do_reset();
        s = 0;
        for (int m = 0; m < 2; m++)
            for (int f = 0; f < 24; f += 2) begin
                frame(f);
                check("R10 trans bit", dl_bit, fifo_stream(s, 1, 8'hFF));
                s++;
            end

        // R11: aligned start
        fmem[0] = 8'h81; fcnt = 0; mode = 2'd1; fill_idle = 1'b0;
        mf_align = 1'b1; fmt_f72 = 1'b0;
        do_reset();
        s = 0;
        for (int m = 0; m < 2; m++)
            for (int f = 0; f < 24; f++) begin
                frame(f);
                if (f % 2 == 0) begin
                    if (s < 12)      check("R11 fill before start", dl_bit, 8'h7E >> (s % 8) & 1);
                    else if (s < 20) check("R11 data at boundary", dl_bit, 8'h81 >> (s - 12) & 1);
                    else             check("R11 fill after data", dl_bit, 8'h7E >> ((s - 20) % 8) & 1);
                    s++;
                end
                if (m == 0 && f == 9)  fcnt = 1;
                if (m == 0 && f == 23) check("R11 held off", fptr, 0);
            end
        check("R11 byte read once", fptr, 1);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule